// File: doc/BRIEF.md
# Destination Address Acceptance Filter

This block decides, for every received Ethernet frame, whether the frame should be kept, looking only at its 48-bit destination address. A configuration port loads a station address, a 64-entry multicast hash table (two 32-bit words) and three mode bits. The receive path presents a destination address with a one-cycle strobe. Exactly two cycles later the block returns a result strobe, an accept flag and a code that tells why the frame was accepted.

Group (multicast) addresses are matched through a hash. A CRC-32 is computed over the six address bytes inside the block. The top six bits of that CRC index the table: index bit 5 picks the table word and bits 4:0 pick the bit inside that word. Unicast addresses need an exact match with the station address. The broadcast address is always kept. Promiscuous mode keeps everything. Configuration is sampled when the strobe arrives, so a write never disturbs a lookup that is already in progress.

Top module: `mcast_hash_filter`

## Requirements
- R1: Configuration writes (`cfg_we`) select a register with `cfg_addr`:
  - 0 is the station low word. Address byte 0 sits in bits 7:0 and byte 3 in bits 31:24.
  - 1 is the station high word. Byte 4 sits in bits 7:0 and byte 5 in bits 15:8.
  - 2 is hash word 0, covering indices 0..31.
  - 3 is hash word 1, covering indices 32..63.
  - 4 is the mode register: bit 0 promiscuous, bit 1 keep-all-group, bit 2 hash enable.
  - `da_addr` carries address byte k in bits 8k+7:8k.
- R2: For every cycle with `da_valid` high, `res_valid` is high exactly two clock cycles later and in no other cycle. Back-to-back strobes give back-to-back results.
- R3: With promiscuous mode set, every address is accepted with reason code 1.
- R4: The all-ones (broadcast) address is always accepted. When promiscuous mode is off, its reason code is 2.
- R5: A unicast address (byte 0 bit 0 clear) is accepted with reason 3 only on an exact 48-bit match with the station address. Any other unicast address is rejected unless promiscuous mode is set.
- R6: A group address (byte 0 bit 0 set, not broadcast) with keep-all-group set is accepted with reason 4. This does not depend on the hash table.
- R7: With hash mode set, the index is the top 6 bits of a CRC-32 over the address:
  - polynomial 0x04C11DB7, start value all ones;
  - bytes 0 to 5 in order, each byte least significant bit first;
  - no final inversion.
  - A group address is accepted with reason 5 when table bit `index` is 1. Index bit 5 set selects hash word 1, and bits 4:0 select the bit inside the word.
- R8: A group address is rejected when keep-all-group is off and either hash mode is off or its table bit is 0.
- R9: A configuration write in the same cycle as a strobe, or in a later cycle, does not change that lookup's result. It applies from the next strobe on.
- R10: Reset clears all configuration and the result outputs. After reset, a non-matching unicast address is rejected.
- R11: Whenever the result is a reject, or `res_valid` is low, `res_reason` is 0 and `res_accept` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address strobe |
| da_addr | input | 48 | Destination address, byte k in bits 8k+7:8k |
| res_valid | output | 1 | Result strobe, two cycles after `da_valid` |
| res_accept | output | 1 | Frame accepted |
| res_reason | output | 3 | 0 reject, 1 promiscuous, 2 broadcast, 3 station, 4 keep-all-group, 5 hash |

## Verification
A wrong CRC index, or a swapped table word, shows up as a wrong accept on the very first hashed lookup of a chosen address. It is caught by programming a table that is all ones except that address's bit, and then a table with only that bit set. A pipeline slip shows up as `res_valid` one cycle early or late. A result taken from the live configuration instead of the sampled one shows up when a mode write lands while the lookup is in flight. Each error is visible at the ports within two cycles of the strobe concerned.

// File: rtl/mf_pkg.sv
package mf_pkg;
    localparam int ADDR_W    = 48;
    localparam int WORD_W    = 32;
    localparam int HASH_W    = 6;
    localparam int CRC_W     = 32;
    localparam int TBL_N     = 1 << HASH_W;
    localparam int TBL_WORDS = TBL_N / WORD_W;
    localparam int STA_HI_W  = ADDR_W - WORD_W;
    localparam int REG_AW    = 3;
    localparam int MODE_W    = 3;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;

    typedef enum logic [2:0] {
        WHY_NONE    = 3'd0,
        WHY_PROMISC = 3'd1,
        WHY_BCAST   = 3'd2,
        WHY_STATION = 3'd3,
        WHY_ALLGRP  = 3'd4,
        WHY_HASH    = 3'd5
    } why_e;

    localparam logic [REG_AW-1:0] RA_STA_LO = 3'd0;
    localparam logic [REG_AW-1:0] RA_STA_HI = 3'd1;
    localparam logic [REG_AW-1:0] RA_TBL0   = 3'd2;
    localparam logic [REG_AW-1:0] RA_MODE   = 3'd4;

    typedef struct packed {
        logic hash_en;
        logic all_grp;
        logic promisc;
    } mode_t;

    typedef struct packed {
        logic [ADDR_W-1:0] station;
        logic [TBL_N-1:0]  tbl;
        mode_t             mode;
    } cfg_t;

    typedef struct packed {
        logic  valid;
        logic  bcast;
        logic  group;
        logic  sta_hit;
        logic  tbl_hit;
        mode_t mode;
    } probe_t;

    // Serial CRC over the address, bit i of the vector fed at step i
    function automatic logic [HASH_W-1:0] hash_index(input logic [ADDR_W-1:0] a);
        logic [CRC_W-1:0] c;
        logic fb;
        c = '1;
        for (int i = 0; i < ADDR_W; i++) begin
            fb = c[CRC_W-1] ^ a[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c[CRC_W-1 -: HASH_W];
    endfunction
endpackage

// File: rtl/mf_cfg_regs.sv
module mf_cfg_regs
    import mf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [REG_AW-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output cfg_t                cfg_o
);
    logic [WORD_W-1:0]   sta_lo_q;
    logic [STA_HI_W-1:0] sta_hi_q;
    mode_t               mode_q;
    logic [WORD_W-1:0]   tbl_q [TBL_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            sta_lo_q <= '0;
            sta_hi_q <= '0;
            mode_q   <= '0;
        end else if (we) begin
            if (addr == RA_STA_LO) sta_lo_q <= wdata;
            if (addr == RA_STA_HI) sta_hi_q <= wdata[STA_HI_W-1:0];
            if (addr == RA_MODE)   mode_q   <= mode_t'(wdata[MODE_W-1:0]);
        end
    end

    for (genvar g = 0; g < TBL_WORDS; g++) begin : g_tbl
        localparam logic [REG_AW-1:0] MY_ADDR = RA_TBL0 + REG_AW'(g);
        always_ff @(posedge clk) begin
            if (rst)                          tbl_q[g] <= '0;
            else if (we && addr == MY_ADDR)   tbl_q[g] <= wdata;
        end
        assign cfg_o.tbl[g*WORD_W +: WORD_W] = tbl_q[g];
    end

    assign cfg_o.station = {sta_hi_q, sta_lo_q};
    assign cfg_o.mode    = mode_q;
endmodule

// File: rtl/mf_hash_index.sv
module mf_hash_index
    import mf_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    output logic [HASH_W-1:0] idx_o
);
    assign idx_o = hash_index(addr_i);
endmodule

// File: rtl/mf_verdict.sv
module mf_verdict
    import mf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  probe_t probe_i,
    output logic   valid_o,
    output logic   accept_o,
    output why_e   why_o
);
    probe_t p_q;
    why_e   why_d;

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= probe_i;
    end

    always_comb begin
        why_d = WHY_NONE;
        if (p_q.valid) begin
            if (p_q.mode.promisc)                       why_d = WHY_PROMISC;
            else if (p_q.bcast)                         why_d = WHY_BCAST;
            else if (!p_q.group)                        why_d = p_q.sta_hit ? WHY_STATION : WHY_NONE;
            else if (p_q.mode.all_grp)                  why_d = WHY_ALLGRP;
            else if (p_q.mode.hash_en && p_q.tbl_hit)   why_d = WHY_HASH;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o  <= 1'b0;
            accept_o <= 1'b0;
            why_o    <= WHY_NONE;
        end else begin
            valid_o  <= p_q.valid;
            accept_o <= (why_d != WHY_NONE);
            why_o    <= why_d;
        end
    end
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
    import mf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              da_valid,
    input  logic [47:0]       da_addr,
    output logic              res_valid,
    output logic              res_accept,
    output logic [2:0]        res_reason
);
    cfg_t              cfg_q;
    logic [HASH_W-1:0] idx;
    probe_t            probe;
    why_e              why;

    mf_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg_o (cfg_q)
    );

    mf_hash_index u_hash (
        .addr_i (da_addr),
        .idx_o  (idx)
    );

    always_comb begin
        probe.valid   = da_valid;
        probe.bcast   = &da_addr;
        probe.group   = da_addr[0];
        probe.sta_hit = (da_addr == cfg_q.station);
        probe.tbl_hit = cfg_q.tbl[idx];
        probe.mode    = cfg_q.mode;
    end

    mf_verdict u_verdict (
        .clk      (clk),
        .rst      (rst),
        .probe_i  (probe),
        .valid_o  (res_valid),
        .accept_o (res_accept),
        .why_o    (why)
    );

    assign res_reason = why;
endmodule

// File: rtl/mf_filter_chk.sv
module mf_filter_chk
    import mf_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        da_valid,
    input logic [47:0] da_addr,
    input logic        res_valid,
    input logic        res_accept,
    input logic [2:0]  res_reason,
    input cfg_t        cfg_q
);
    logic [1:0] live_cyc;
    always_ff @(posedge clk) begin
        if (rst)                live_cyc <= '0;
        else if (live_cyc != 2'd3) live_cyc <= live_cyc + 2'd1;
    end

    // R2
    latency_two_chk: assert property (@(posedge clk) disable iff (rst)
        (live_cyc >= 2'd2) |-> (res_valid == $past(da_valid, 2)));

    // R3
    promisc_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (da_valid && cfg_q.mode.promisc) |=> ##1 (res_accept && res_reason == 3'd1));

    // R4
    bcast_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (da_valid && (&da_addr)) |=> ##1 res_accept);

    // R5
    unicast_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (da_valid && !da_addr[0] && !cfg_q.mode.promisc && da_addr != cfg_q.station)
        |=> ##1 !res_accept);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!res_accept && res_reason == 3'd0));

    // R11
    reason_agree_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_accept == (res_reason != 3'd0)));
endmodule

bind mcast_hash_filter mf_filter_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .da_valid   (da_valid),
    .da_addr    (da_addr),
    .res_valid  (res_valid),
    .res_accept (res_accept),
    .res_reason (res_reason),
    .cfg_q      (cfg_q)
);

// File: tb/mcast_hash_filter_tb.sv
module mcast_hash_filter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        da_valid = 1'b0;
    logic [47:0] da_addr = '0;
    logic        res_valid;
    logic        res_accept;
    logic [2:0]  res_reason;

    int n_chk = 0;
    int n_fail = 0;
    logic       got_v, got_a;
    logic [2:0] got_r;

    always #10 clk = ~clk;

    mcast_hash_filter u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da_addr(da_addr),
        .res_valid(res_valid), .res_accept(res_accept), .res_reason(res_reason)
    );

    localparam logic [47:0] STA  = 48'h5544_3322_1102;
    localparam logic [47:0] MC_A = 48'hfb00_005e_0001;
    localparam logic [47:0] MC_B = 48'h0000_0000_0033;
    localparam logic [47:0] BC   = 48'hffff_ffff_ffff;
    localparam logic [47:0] UMIS = 48'h5544_3322_1106;
    localparam logic [47:0] UTOP = 48'hd544_3322_1102;

    typedef struct packed {
        logic [47:0] da;
        logic [2:0]  mode;
        logic        acc;
        logic [2:0]  why;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{STA,  3'b000, 1'b1, 3'd3},
        '{UMIS, 3'b000, 1'b0, 3'd0},
        '{UTOP, 3'b000, 1'b0, 3'd0},
        '{UMIS, 3'b001, 1'b1, 3'd1},
        '{BC,   3'b000, 1'b1, 3'd2},
        '{BC,   3'b001, 1'b1, 3'd1},
        '{MC_A, 3'b000, 1'b0, 3'd0},
        '{MC_A, 3'b010, 1'b1, 3'd4},
        '{MC_A, 3'b100, 1'b0, 3'd0},
        '{MC_B, 3'b011, 1'b1, 3'd1}
    };

    // Bench model of the index: byte loop, LSB first, no inversion
    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] r;
        logic b;
        r = 32'hffff_ffff;
        for (int k = 0; k < 6; k++) begin
            for (int j = 0; j < 8; j++) begin
                b = a[8*k + j] ^ r[31];
                r = r << 1;
                if (b) r = r ^ 32'h04c1_1db7;
            end
        end
        return r[31:26];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic put_tbl(input logic [63:0] t);
        wr(3'd2, t[31:0]);
        wr(3'd3, t[63:32]);
    endtask

    task automatic look(input logic [47:0] a);
        da_valid = 1'b1; da_addr = a;
        @(negedge clk);
        da_valid = 1'b0;
        chk("R2 no early result", 32'(res_valid), 32'd0);
        @(negedge clk);
        got_v = res_valid; got_a = res_accept; got_r = res_reason;
        chk("R2 result after two cycles", 32'(got_v), 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [5:0]  ix;
        logic [63:0] t;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 res_valid after reset", 32'(res_valid), 32'd0);
        chk("R11 reason idle", 32'(res_reason), 32'd0);
        look(UMIS);
        chk("R10 unicast rejected after reset", 32'(got_a), 32'd0);

        // R1 station programming
        wr(3'd0, 32'h3322_1102);
        wr(3'd1, 32'h0000_5544);

        for (int v = 0; v < NV; v++) begin
            wr(3'd4, {29'd0, VECS[v].mode});
            look(VECS[v].da);
            chk($sformatf("R3/R4/R5/R6/R8 vec%0d accept", v), 32'(got_a), 32'(VECS[v].acc));
            chk($sformatf("R11 vec%0d reason", v), 32'(got_r), 32'(VECS[v].why));
        end

        // R7 hash lookups, word select exercised for two addresses
        wr(3'd4, 32'd4);
        for (int n = 0; n < 2; n++) begin
            logic [47:0] a;
            a  = (n == 0) ? MC_A : MC_B;
            ix = ref_idx(a);
            put_tbl(~(64'd1 << ix));
            look(a);
            chk("R8 hash bit clear rejects", 32'(got_a), 32'd0);
            t = 64'd1 << ix;
            put_tbl({t[31:0], t[63:32]});
            look(a);
            chk("R7 wrong word rejects", 32'(got_a), 32'd0);
            put_tbl(64'd1 << ix);
            look(a);
            chk("R7 hash bit set accepts", 32'(got_a), 32'd1);
            chk("R7 hash reason", 32'(got_r), 32'd5);
        end
        // R6 keep-all-group wins over a cleared hash bit
        put_tbl(64'd0);
        wr(3'd4, 32'd6);
        look(MC_A);
        chk("R6 all-group reason", 32'(got_r), 32'd4);

        // R9 write while in flight
        wr(3'd4, 32'd0);
        da_valid = 1'b1; da_addr = UMIS;
        cfg_we = 1'b1; cfg_addr = 3'd4; cfg_wdata = 32'd1;
        @(negedge clk);
        da_valid = 1'b0; cfg_wdata = 32'd1;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R9 in-flight lookup unaffected", 32'(res_accept), 32'd0);
        look(UMIS);
        chk("R9 next lookup sees write", 32'(got_r), 32'd1);

        // R2 back-to-back strobes
        wr(3'd4, 32'd0);
        da_valid = 1'b1; da_addr = STA;
        @(negedge clk);
        da_addr = UMIS;
        @(negedge clk);
        da_valid = 1'b0;
        chk("R2 first of pair", {31'd0, res_accept}, 32'd1);
        chk("R2 first valid", 32'(res_valid), 32'd1);
        @(negedge clk);
        chk("R2 second valid", 32'(res_valid), 32'd1);
        chk("R5 second of pair rejected", 32'(res_accept), 32'd0);
        @(negedge clk);
        chk("R2 no extra result", 32'(res_valid), 32'd0);

        // R10 reset clears configuration
        wr(3'd4, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        look(UMIS);
        chk("R10 promisc cleared by reset", 32'(got_a), 32'd0);
        look(STA);
        chk("R10 station cleared by reset", 32'(got_a), 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule